// File: doc/BRIEF.md
# Performance Counter Overflow Interrupt Unit

This block counts clock cycles and hardware events for performance analysis. It also raises a level interrupt when a counter wraps. It holds one 64-bit cycle counter and `NUM_EVT` 32-bit event counters. Each event counter advances on its own event strobe, or on a software-increment register write when its event type is zero. A counter that wraps past its monitored top bit sets its bit in the overflow status register. The interrupt output is asserted while the global enable is on and a status bit is also set in the interrupt-enable mask.

Software reaches every register through a single-cycle register port. `reg_we` with `reg_addr` and `reg_wdata` performs a write, and `reg_rdata` always returns the register selected by `reg_addr`. The counter-enable, interrupt-enable and overflow-status registers are never written directly. Each has a write-one-to-set alias and a write-one-to-clear alias.

Address map (word addresses):
- 0: control. Bit 0 is the global enable, bit 3 divides the cycle count by 64 and bit 6 selects 64-bit cycle overflow. Bits 15:11 are read-only and return `NUM_EVT`.
- 1 and 2: counter-enable set and clear.
- 3 and 4: interrupt-enable set and clear.
- 5 and 6: overflow-status set and clear.
- 7: software increment.
- 8 and 9: cycle counter low and high words.
- 16+n: event counter n.
- 24+n: the 8-bit event type of counter n.

In every mask register, bit n belongs to event counter n and bit 31 belongs to the cycle counter. `NUM_EVT` may be 1 to 8.

Top module: `perfmon_ovf_irq`

## Requirements
- R1: After reset all counters, event types, enable masks and status bits read zero and `irq` is low. The control register reads `NUM_EVT` in bits 15:11.
- R2: Event counter n adds one in each cycle where `evt_pulse[n]` is high, its counter-enable bit n is set and its event type is nonzero. With the enable bit clear it holds its value and never flags overflow.
- R3: An event counter flags overflow only when its bit 31 goes from 1 to 0 on an increment (0xFFFFFFFF to 0), and this sets status bit n. A step from 0x7FFFFFFF to 0x80000000 and a direct write to the counter set nothing.
- R4: The cycle counter (enable bit 31) adds one every clock while control bit 3 is clear, and once per 64 clocks while it is set.
- R5: The cycle counter sets status bit 31 when bit 31 falls while control bit 6 is clear, and when bit 63 falls while control bit 6 is set.
- R6: A write to address 7 adds one to each counter n whose written bit n is 1, whose enable bit is set and whose event type is 0x00. A wrap on this increment flags overflow, and a counter with type 0x00 ignores `evt_pulse`.
- R7: Each set alias sets the bits written as 1, and each clear alias clears them. Written values are first masked to bits `NUM_EVT-1:0` plus bit 31, so unimplemented bits always read zero.
- R8: `irq` is registered. One cycle after any state change it equals control bit 0 AND (interrupt-enable AND overflow-status is nonzero).
- R9: When a counter overflow and a software clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_pulse | input | NUM_EVT | Per-counter event strobes |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench builds the block with `NUM_EVT = 3` and the default divide-by-64 prescaler. With three counters, bits 3 to 30 of every mask register are unimplemented, so a write of all ones shows the masking directly. The bench drives each counter from a value just below a boundary, which puts the 31-bit and 63-bit wrap points, the falsely suggestive 0x7FFFFFFF step and the overflow-versus-clear collision within a few cycles. It measures cycle counts over windows of exact multiples of 64 clocks, so the prescaled rate can be checked without knowing the prescaler phase.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int DATA_W = 32;
  localparam int TYPE_W = 8;
  localparam int ADDR_W = 5;
  localparam int CYC_STATUS_BIT = 31;

  localparam logic [ADDR_W-1:0] A_CTRL      = 5'd0;
  localparam logic [ADDR_W-1:0] A_CNTEN_SET = 5'd1;
  localparam logic [ADDR_W-1:0] A_CNTEN_CLR = 5'd2;
  localparam logic [ADDR_W-1:0] A_INTEN_SET = 5'd3;
  localparam logic [ADDR_W-1:0] A_INTEN_CLR = 5'd4;
  localparam logic [ADDR_W-1:0] A_OVF_SET   = 5'd5;
  localparam logic [ADDR_W-1:0] A_OVF_CLR   = 5'd6;
  localparam logic [ADDR_W-1:0] A_SWINC     = 5'd7;
  localparam logic [ADDR_W-1:0] A_CYC_LO    = 5'd8;
  localparam logic [ADDR_W-1:0] A_CYC_HI    = 5'd9;
  localparam int A_EVCNT_BASE  = 16;
  localparam int A_EVTYPE_BASE = 24;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_DIV_BIT  = 3;
  localparam int CTRL_LONG_BIT = 6;
  localparam int CTRL_NUM_LSB  = 11;

  // Wrap detector: monitored bit was set before and is clear after.
  function automatic logic top_bit_fell(input logic [63:0] old_v,
                                        input logic [63:0] new_v,
                                        input int unsigned pos);
    return old_v[pos] & ~new_v[pos];
  endfunction

  // Implemented bits of every mask register: event counters plus the cycle bit.
  function automatic logic [DATA_W-1:0] impl_mask(input int unsigned n);
    return (DATA_W'(1) << CYC_STATUS_BIT) | ((DATA_W'(1) << n) - DATA_W'(1));
  endfunction
endpackage

// File: rtl/perfmon_w1_reg.sv
module perfmon_w1_reg
  import perfmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] hw_set,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] set_bits;
  logic [DATA_W-1:0] clr_bits;

  always_comb begin
    set_bits = set_we ? (wdata & mask) : '0;
    clr_bits = clr_we ? (wdata & mask) : '0;
  end

  // Hardware set is applied last so a simultaneous clear cannot drop it.
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_bits) | set_bits | (hw_set & mask);
  end
endmodule

// File: rtl/perfmon_evt_counter.sv
module perfmon_evt_counter
  import perfmon_pkg::*;
#(
  parameter int CNT_W = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              evt_pulse,
  input  logic              sw_inc,
  input  logic              wr_count,
  input  logic              wr_type,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [TYPE_W-1:0] type_wdata,
  output logic [CNT_W-1:0]  count,
  output logic [TYPE_W-1:0] evtype,
  output logic              ovf_event
);
  logic             bump;
  logic [CNT_W-1:0] count_inc;

  always_comb begin
    bump      = enable && ((evtype == '0) ? sw_inc : evt_pulse);
    count_inc = count + CNT_W'(1);
    ovf_event = bump && !wr_count &&
                top_bit_fell(64'(count), 64'(count_inc), CNT_W - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      evtype <= '0;
    end else begin
      if (wr_count)  count <= wdata;
      else if (bump) count <= count_inc;
      if (wr_type) evtype <= type_wdata;
    end
  end
endmodule

// File: rtl/perfmon_cyc_counter.sv
module perfmon_cyc_counter
  import perfmon_pkg::*;
#(
  parameter int CYC_W     = 64,
  parameter int DIV       = 64,
  parameter int SHORT_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              div_sel,
  input  logic              long_sel,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [CYC_W-1:0]  count,
  output logic              tick,
  output logic              ovf_event
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(DIV - 1);

  logic [PW-1:0]    presc;
  logic [CYC_W-1:0] count_inc;
  int unsigned      mon_pos;

  always_comb begin
    tick      = enable && (!div_sel || presc == PRESC_LAST);
    count_inc = count + CYC_W'(1);
    mon_pos   = long_sel ? CYC_W - 1 : SHORT_BIT;
    ovf_event = tick && !(wr_lo || wr_hi) &&
                top_bit_fell(64'(count), 64'(count_inc), mon_pos);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc <= '0;
      count <= '0;
    end else begin
      if (enable && div_sel)
        presc <= (presc == PRESC_LAST) ? '0 : presc + PW'(1);
      if (wr_lo || wr_hi) begin
        if (wr_lo) count[DATA_W-1:0] <= wdata;
        if (wr_hi) count[CYC_W-1:DATA_W] <= wdata[CYC_W-DATA_W-1:0];
      end else if (tick) begin
        count <= count_inc;
      end
    end
  end
endmodule

// File: rtl/perfmon_ovf_irq.sv
module perfmon_ovf_irq
  import perfmon_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int CYC_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic              irq
);
  localparam logic [DATA_W-1:0] IMPL = impl_mask(NUM_EVT);
  localparam int CYC_W = 64;

  logic ctrl_en, ctrl_div, ctrl_long;
  logic [DATA_W-1:0] cnten_q, inten_q, ovf_q, ovf_evt;
  logic [NUM_EVT-1:0] swinc_vec, evt_ovf;
  logic [DATA_W-1:0] evt_cnt  [NUM_EVT];
  logic [TYPE_W-1:0] evt_type [NUM_EVT];
  logic [CYC_W-1:0] cyc_cnt;
  logic cyc_tick, cyc_ovf;

  function automatic logic wr_at(input logic [ADDR_W-1:0] a);
    return reg_we && (reg_addr == a);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0; ctrl_div <= 1'b0; ctrl_long <= 1'b0;
    end else if (wr_at(A_CTRL)) begin
      ctrl_en   <= reg_wdata[CTRL_EN_BIT];
      ctrl_div  <= reg_wdata[CTRL_DIV_BIT];
      ctrl_long <= reg_wdata[CTRL_LONG_BIT];
    end
  end

  always_comb begin
    swinc_vec = wr_at(A_SWINC) ? reg_wdata[NUM_EVT-1:0] : '0;
    ovf_evt = '0;
    ovf_evt[NUM_EVT-1:0] = evt_ovf;
    ovf_evt[CYC_STATUS_BIT] = cyc_ovf;
  end

  perfmon_w1_reg u_cnten (
    .clk(clk), .rst_n(rst_n), .set_we(wr_at(A_CNTEN_SET)), .clr_we(wr_at(A_CNTEN_CLR)),
    .wdata(reg_wdata), .mask(IMPL), .hw_set('0), .q(cnten_q));
  perfmon_w1_reg u_inten (
    .clk(clk), .rst_n(rst_n), .set_we(wr_at(A_INTEN_SET)), .clr_we(wr_at(A_INTEN_CLR)),
    .wdata(reg_wdata), .mask(IMPL), .hw_set('0), .q(inten_q));
  perfmon_w1_reg u_ovf (
    .clk(clk), .rst_n(rst_n), .set_we(wr_at(A_OVF_SET)), .clr_we(wr_at(A_OVF_CLR)),
    .wdata(reg_wdata), .mask(IMPL), .hw_set(ovf_evt), .q(ovf_q));

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    perfmon_evt_counter #(.CNT_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .enable(cnten_q[g]), .evt_pulse(evt_pulse[g]),
      .sw_inc(swinc_vec[g]),
      .wr_count(wr_at(ADDR_W'(A_EVCNT_BASE + g))),
      .wr_type(wr_at(ADDR_W'(A_EVTYPE_BASE + g))),
      .wdata(reg_wdata), .type_wdata(reg_wdata[TYPE_W-1:0]),
      .count(evt_cnt[g]), .evtype(evt_type[g]), .ovf_event(evt_ovf[g]));
  end

  perfmon_cyc_counter #(.CYC_W(CYC_W), .DIV(CYC_DIV), .SHORT_BIT(31)) u_cyc (
    .clk(clk), .rst_n(rst_n), .enable(cnten_q[CYC_STATUS_BIT]),
    .div_sel(ctrl_div), .long_sel(ctrl_long),
    .wr_lo(wr_at(A_CYC_LO)), .wr_hi(wr_at(A_CYC_HI)), .wdata(reg_wdata),
    .count(cyc_cnt), .tick(cyc_tick), .ovf_event(cyc_ovf));

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= ctrl_en && ((inten_q & ovf_q) != '0);
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[CTRL_EN_BIT]   = ctrl_en;
        reg_rdata[CTRL_DIV_BIT]  = ctrl_div;
        reg_rdata[CTRL_LONG_BIT] = ctrl_long;
        reg_rdata[CTRL_NUM_LSB +: 5] = 5'(NUM_EVT);
      end
      A_CNTEN_SET, A_CNTEN_CLR: reg_rdata = cnten_q;
      A_INTEN_SET, A_INTEN_CLR: reg_rdata = inten_q;
      A_OVF_SET, A_OVF_CLR:     reg_rdata = ovf_q;
      A_CYC_LO: reg_rdata = cyc_cnt[DATA_W-1:0];
      A_CYC_HI: reg_rdata = cyc_cnt[CYC_W-1:DATA_W];
      default: begin
        for (int i = 0; i < NUM_EVT; i++) begin
          if (reg_addr == ADDR_W'(A_EVCNT_BASE + i))  reg_rdata = evt_cnt[i];
          if (reg_addr == ADDR_W'(A_EVTYPE_BASE + i)) reg_rdata = DATA_W'(evt_type[i]);
        end
      end
    endcase
  end
endmodule

// File: rtl/perfmon_ovf_irq_chk.sv
module perfmon_ovf_irq_chk
  import perfmon_pkg::*;
#(
  parameter int NUM_EVT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              irq,
  input logic              ctrl_en,
  input logic [DATA_W-1:0] ovf_evt,
  input logic [DATA_W-1:0] ovf_q,
  input logic [DATA_W-1:0] inten_q,
  input logic [DATA_W-1:0] cnten_q
);
  localparam logic [DATA_W-1:0] IMPL = impl_mask(NUM_EVT);

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !irq);
  assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((inten_q & ovf_q) == '0) |=> !irq);
  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && ((inten_q & ovf_q) != '0)) |=> irq);
  assert_new_ovf_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt != '0) |=> ((ovf_q & $past(ovf_evt)) == $past(ovf_evt)));
  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt & ~cnten_q) == '0);
  assert_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_q | inten_q | cnten_q) & ~IMPL) == '0);
  assert_ovf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && ovf_evt == '0) |=> $stable(ovf_q));
endmodule

bind perfmon_ovf_irq perfmon_ovf_irq_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .irq(irq), .ctrl_en(ctrl_en),
  .ovf_evt(ovf_evt), .ovf_q(ovf_q), .inten_q(inten_q), .cnten_q(cnten_q));

// File: tb/perfmon_ovf_irq_test.sv
module perfmon_ovf_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NEV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NEV-1:0] evt_pulse = '0;
  logic irq;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  perfmon_ovf_irq #(.NUM_EVT(NEV), .CYC_DIV(64)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v, a0, b0, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'd0, v);  check("R1 ctrl", v, 32'(NEV) << 11);
    rd(5'd1, v);  check("R1 cnten", v, 0);
    rd(5'd3, v);  check("R1 inten", v, 0);
    rd(5'd5, v);  check("R1 ovf", v, 0);
    rd(5'd16, v); check("R1 cnt0", v, 0);
    rd(5'd8, v);  check("R1 cyc", v, 0);
    check("R1 irq", 32'(irq), 0);

    // R2 event strobes, counter 2 disabled
    wr(5'd24, 32'h11); wr(5'd25, 32'h05); wr(5'd26, 32'h22);
    wr(5'd1, 32'h3);
    for (int i = 0; i < 8; i++) begin
      evt_pulse = {1'b1, (i % 2 == 0), 1'b1};
      @(negedge clk);
    end
    evt_pulse = '0;
    rd(5'd16, v); check("R2 cnt0 every cycle", v, 8);
    rd(5'd17, v); check("R2 cnt1 alternate", v, 4);
    rd(5'd18, v); check("R2 cnt2 disabled holds", v, 0);
    rd(5'd5, v);  check("R2 no ovf", v, 0);

    // R3 wrap points
    wr(5'd16, 32'hFFFF_FFFE); wr(5'd17, 32'h7FFF_FFFF);
    rd(5'd5, v);  check("R3 direct write no flag", v, 0);
    evt_pulse = 3'b011; @(negedge clk); evt_pulse = '0;
    rd(5'd5, v);  check("R3 no flag before wrap", v, 0);
    rd(5'd17, v); check("R3 cnt1 at 0x80000000", v, 32'h8000_0000);
    evt_pulse = 3'b011; @(negedge clk); evt_pulse = '0;
    rd(5'd16, v); check("R3 cnt0 wrapped", v, 0);
    rd(5'd5, v);  check("R3 only bit0 flagged", v, 32'h1);

    // R8 interrupt gating and registered timing
    wr(5'd3, 32'h1);
    @(negedge clk);
    check("R8 gated by global enable", 32'(irq), 0);
    wr(5'd0, 32'h1);
    check("R8 irq one cycle late", 32'(irq), 0);
    @(negedge clk);
    check("R8 irq asserted", 32'(irq), 1);
    wr(5'd6, 32'h1);
    check("R8 irq held one cycle", 32'(irq), 1);
    @(negedge clk);
    check("R8 irq drops after clear", 32'(irq), 0);

    // R7 masked set/clear aliases
    wr(5'd5, 32'hFFFF_FFFF);
    rd(5'd5, v); check("R7 ovf set masked", v, 32'h8000_0007);
    @(negedge clk);
    check("R8 irq on bit0 via set alias", 32'(irq), 1);
    wr(5'd6, 32'h5);
    rd(5'd6, v); check("R7 ovf clear partial", v, 32'h8000_0002);
    wr(5'd6, 32'hFFFF_FFFF);
    rd(5'd5, v); check("R7 ovf clear all", v, 0);
    wr(5'd3, 32'hFFFF_FFFF);
    rd(5'd3, v); check("R7 inten set masked", v, 32'h8000_0007);
    wr(5'd4, 32'h7FFF_FFFF);
    rd(5'd4, v); check("R7 inten clear", v, 32'h8000_0000);
    wr(5'd1, 32'h0000_00F0);
    rd(5'd1, v); check("R7 cnten unimplemented ignored", v, 32'h3);
    wr(5'd2, 32'h0);
    rd(5'd1, v); check("R7 clear of zero no effect", v, 32'h3);

    // R6 software increment
    wr(5'd26, 32'h0); wr(5'd1, 32'h4); wr(5'd18, 32'hFFFF_FFFF);
    rd(5'd16, a0); rd(5'd17, b0);
    evt_pulse = 3'b100; repeat (3) @(negedge clk); evt_pulse = '0;
    rd(5'd18, v); check("R6 type0 ignores strobes", v, 32'hFFFF_FFFF);
    wr(5'd7, 32'h7);
    rd(5'd18, v); check("R6 swinc wraps cnt2", v, 0);
    rd(5'd16, v); check("R6 nonzero type not bumped cnt0", v, a0);
    rd(5'd17, v); check("R6 nonzero type not bumped cnt1", v, b0);
    rd(5'd5, v);  check("R6 swinc overflow flagged", v, 32'h4);
    wr(5'd2, 32'h4); wr(5'd7, 32'h4);
    rd(5'd18, v); check("R6 disabled not bumped", v, 0);

    // R9 overflow beats simultaneous clear
    wr(5'd6, 32'hFFFF_FFFF); wr(5'd16, 32'hFFFF_FFFF); wr(5'd5, 32'h1);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'd6; reg_wdata = 32'h1; evt_pulse = 3'b001;
    @(negedge clk);
    reg_we = 1'b0; evt_pulse = '0;
    rd(5'd5, v);  check("R9 new overflow wins", v, 32'h1);
    rd(5'd16, v); check("R9 counter wrapped", v, 0);
    wr(5'd6, 32'h1);
    rd(5'd5, v);  check("R9 plain clear works", v, 0);

    // R4 cycle counting rates
    wr(5'd1, 32'h8000_0000);
    rd(5'd8, a0); repeat (100) @(negedge clk); rd(5'd8, b0);
    check("R4 undivided rate", b0 - a0, 100);
    wr(5'd0, 32'h9);
    rd(5'd8, a0); repeat (640) @(negedge clk); rd(5'd8, b0);
    check("R4 divided rate", b0 - a0, 10);
    wr(5'd2, 32'h8000_0000);
    rd(5'd8, a0); repeat (70) @(negedge clk); rd(5'd8, b0);
    check("R4 disabled holds", b0, a0);

    // R5 cycle overflow point
    wr(5'd0, 32'h1);
    wr(5'd8, 32'hFFFF_FFFE); wr(5'd9, 32'h0); wr(5'd6, 32'hFFFF_FFFF);
    wr(5'd1, 32'h8000_0000); repeat (5) @(negedge clk);
    rd(5'd5, v); check("R5 short wrap flags bit31", v, 32'h8000_0000);
    rd(5'd9, v); check("R5 carry into high word", v, 1);
    wr(5'd2, 32'h8000_0000); wr(5'd0, 32'h41);
    wr(5'd8, 32'hFFFF_FFFE); wr(5'd9, 32'h0); wr(5'd6, 32'hFFFF_FFFF);
    wr(5'd1, 32'h8000_0000); repeat (5) @(negedge clk);
    rd(5'd5, v); check("R5 long mode ignores bit31", v, 0);
    wr(5'd2, 32'h8000_0000);
    wr(5'd8, 32'hFFFF_FFFE); wr(5'd9, 32'hFFFF_FFFF);
    wr(5'd1, 32'h8000_0000); repeat (5) @(negedge clk);
    rd(5'd5, v); check("R5 long wrap flags bit31", v, 32'h8000_0000);
    rd(5'd9, c0); check("R5 high word wrapped", c0, 0);
    @(negedge clk);
    check("R8 irq from cycle overflow", 32'(irq), 1);

    summary();
  end
endmodule